// File: doc/BRIEF.md
# Selectable I/Q Digital Upmixer

This block shifts a complex baseband stream in frequency at the full sample rate, just before a pair of DAC channels. Each clock it can accept one signed I sample and one signed Q sample, qualified by a valid flag. A small mode word selects the local-oscillator rate: none, half the sample rate or a quarter of the sample rate. It also selects between two kinds of mixing. Complex mixing is an image-rejecting rotation. Real mixing multiplies each channel by the cosine on its own, which leaves image pairs on both sides of the oscillator.

Because the oscillator only ever takes the values +1, 0 and -1, the mixer needs no multipliers: it only negates, swaps and zeroes samples. Each mixed channel then passes through its own gain and offset trim. This trim lets a system cancel carrier leakage and sideband imbalance in an external analog modulator. The result is clamped to the sample width and presented as two's complement or offset binary.

Top module: `iq_upmixer`

## Requirements
- R1: While reset is asserted and right after it is released, `out_vld` is 0 and `out_i` and `out_q` are 0.
- R2: With `mode[1:0]` equal to 0 or 3 there is no frequency shift: each channel's mixer output equals its input sample.
- R3: With `mode[1:0]` equal to 1, both channels are multiplied by (-1)^n, in complex and in real mixing. Here n counts valid samples since the last phase restart, and the first sample after a restart has n = 0.
- R4: With `mode[1:0]` equal to 2 and `mode[2]` equal to 0, the outputs are I·cos − Q·sin and I·sin + Q·cos. Over n mod 4 = 0..3, cos is +1, 0, −1, 0 and sin is 0, +1, 0, −1.
- R5: With `mode[1:0]` equal to 2 and `mode[2]` equal to 1, the outputs are I·cos and Q·cos, using the same cosine sequence as R4.
- R6: The phase restarts at reset and whenever `mode[2:0]` differs from its value one clock earlier. The first valid sample at or after such a change uses n = 0. Cycles with `in_vld` low do not advance n.
- R7: Each channel's result is floor(m·G / 2^14) + F. Here m is the mixer output, G is the unsigned 16-bit gain for that channel (16384 is unity) and F is the signed 16-bit offset in LSBs. The two channels use independent settings.
- R8: A trimmed result above 32767 is output as 32767, and one below −32768 is output as −32768. The result never wraps.
- R9: With `mode[3]` equal to 1, the output MSB is inverted, which gives offset binary. With `mode[3]` equal to 0, the output is two's complement.
- R10: An output appears exactly 3 clocks after its input is sampled, and `out_vld` is `in_vld` delayed by 3 clocks. Samples presented on consecutive clocks come out on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample pair is valid |
| in_i | input | 16 | I sample, two's complement |
| in_q | input | 16 | Q sample, two's complement |
| mode | input | 4 | [1:0] oscillator rate, [2] real mixing, [3] offset-binary output |
| gain_i | input | 16 | I-channel gain, unsigned, 16384 = 1.0 |
| gain_q | input | 16 | Q-channel gain, unsigned, 16384 = 1.0 |
| ofs_i | input | 16 | I-channel offset, signed LSBs |
| ofs_q | input | 16 | Q-channel offset, signed LSBs |
| out_vld | output | 1 | Output pair is valid |
| out_i | output | 16 | I-channel result |
| out_q | output | 16 | Q-channel result |

## Verification
The bench builds the block with its default parameters: 16-bit samples, a 16-bit gain with 14 fraction bits and a 16-bit offset. With these values a gain near 4 drives full-scale inputs past both clamp limits, and a gain of one half exposes the floor rounding on negative values. The most negative sample is negated at half rate, which shows that the mixer's extra headroom bit feeds the clamp correctly. A 2-bit phase counter keeps every quarter-rate position reachable within four samples. Both back-to-back streams and isolated samples are used, so the latency is observed with and without pipeline occupancy.

// File: rtl/iqmix_pkg.sv
package iqmix_pkg;
    typedef enum logic [1:0] {
        LO_NONE    = 2'd0,
        LO_HALF    = 2'd1,
        LO_QUARTER = 2'd2,
        LO_RSVD    = 2'd3
    } lo_rate_e;

    localparam int MODE_W        = 4;
    localparam int MODE_REAL_BIT = 2;
    localparam int MODE_OB_BIT   = 3;
    localparam int PIPE_DEPTH    = 3;
endpackage

// File: rtl/iqmix_rotator.sv
module iqmix_rotator
    import iqmix_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic [1:0]           lo_i,
    input  logic                 real_i,
    output logic signed [DW:0]   mix_i,
    output logic signed [DW:0]   mix_q
);
    typedef struct packed {
        logic [1:0]        ph;
        logic [2:0]        cfg;
        logic signed [DW:0] mi;
        logic signed [DW:0] mq;
    } rot_st_t;

    rot_st_t st_d, st_q;

    logic [2:0]         cfg_now;
    logic               cfg_chg;
    logic [1:0]         ph_use;
    logic signed [DW:0] xi, xq, ri, rq;

    always_comb begin
        cfg_now = {real_i, lo_i};
        cfg_chg = (cfg_now != st_q.cfg);
        ph_use  = cfg_chg ? 2'd0 : st_q.ph;
        xi      = {in_i[DW-1], in_i};
        xq      = {in_q[DW-1], in_q};
        ri      = xi;
        rq      = xq;
        case (lo_i)
            LO_HALF: begin
                if (ph_use[0]) begin
                    ri = -xi;
                    rq = -xq;
                end
            end
            LO_QUARTER: begin
                if (real_i) begin
                    case (ph_use)
                        2'd0: begin ri = xi;  rq = xq;  end
                        2'd2: begin ri = -xi; rq = -xq; end
                        default: begin ri = '0; rq = '0; end
                    endcase
                end else begin
                    case (ph_use)
                        2'd0: begin ri = xi;  rq = xq;  end
                        2'd1: begin ri = -xq; rq = xi;  end
                        2'd2: begin ri = -xi; rq = -xq; end
                        default: begin ri = xq; rq = -xi; end
                    endcase
                end
            end
            default: begin
                ri = xi;
                rq = xq;
            end
        endcase
        st_d     = st_q;
        st_d.cfg = cfg_now;
        st_d.ph  = ph_use + {1'b0, vld_i};
        st_d.mi  = ri;
        st_d.mq  = rq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mix_i = st_q.mi;
    assign mix_q = st_q.mq;

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_i == LO_NONE || lo_i == LO_RSVD)
        |=> (mix_i == $past({in_i[DW-1], in_i}) && mix_q == $past({in_q[DW-1], in_q}))); // R2

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_i == LO_QUARTER && !real_i && ({real_i, lo_i} != $past({real_i, lo_i})))
        |=> (mix_i == $past({in_i[DW-1], in_i}) && mix_q == $past({in_q[DW-1], in_q}))); // R6
endmodule

// File: rtl/iqmix_trim.sv
module iqmix_trim #(
    parameter int DW = 16,
    parameter int GW = 16,
    parameter int GF = 14,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW:0]   x,
    input  logic [GW-1:0]        gain,
    input  logic signed [OW-1:0] ofs,
    input  logic                 ob,
    output logic [DW-1:0]        y
);
    localparam int PW = DW + GW + 2;
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (DW-1)) - 64'sd1);
    localparam logic signed [SW-1:0] MINV = SW'(-(64'sd1 <<< (DW-1)));

    typedef struct packed {
        logic signed [PW-1:0] scl;
        logic [DW-1:0]        y;
    } trim_st_t;

    trim_st_t st_d, st_q;

    logic signed [PW-1:0] xe, ge, prod;
    logic signed [SW-1:0] sum, oe;
    logic [DW-1:0]        clip;

    always_comb begin
        xe   = {{(PW-DW-1){x[DW]}}, x};
        ge   = {{(PW-GW){1'b0}}, gain};
        prod = xe * ge;
        oe   = {{(SW-OW){ofs[OW-1]}}, ofs};
        sum  = {st_q.scl[PW-1], st_q.scl} + oe;
        if (sum > MAXV)      clip = MAXV[DW-1:0];
        else if (sum < MINV) clip = MINV[DW-1:0];
        else                 clip = sum[DW-1:0];
        st_d     = st_q;
        st_d.scl = prod >>> GF;
        st_d.y   = {clip[DW-1] ^ ob, clip[DW-2:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y = st_q.y;

    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ob && sum > MAXV) |=> (y == {1'b0, {(DW-1){1'b1}}})); // R8
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ob && sum < MINV) |=> (y == {1'b1, {(DW-1){1'b0}}})); // R8
endmodule

// File: rtl/iq_upmixer.sv
module iq_upmixer
    import iqmix_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 14,
    parameter int OFS_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic [MODE_W-1:0]       mode,
    input  logic [GAIN_W-1:0]       gain_i,
    input  logic [GAIN_W-1:0]       gain_q,
    input  logic signed [OFS_W-1:0] ofs_i,
    input  logic signed [OFS_W-1:0] ofs_q,
    output logic                    out_vld,
    output logic [DATA_W-1:0]       out_i,
    output logic [DATA_W-1:0]       out_q
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [PIPE_DEPTH-1:0] vp;
        logic [1:0]            age;
    } top_st_t;

    top_st_t st_d, st_q;

    logic signed [DATA_W:0]    mix_a  [NCH];
    logic [GAIN_W-1:0]         gain_a [NCH];
    logic signed [OFS_W-1:0]   ofs_a  [NCH];
    logic [DATA_W-1:0]         y_a    [NCH];

    assign gain_a[0] = gain_i;
    assign gain_a[1] = gain_q;
    assign ofs_a[0]  = ofs_i;
    assign ofs_a[1]  = ofs_q;

    iqmix_rotator #(.DW(DATA_W)) u_rot (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_vld),
        .in_i   (in_i),
        .in_q   (in_q),
        .lo_i   (mode[1:0]),
        .real_i (mode[MODE_REAL_BIT]),
        .mix_i  (mix_a[0]),
        .mix_q  (mix_a[1])
    );

    for (genvar c = 0; c < NCH; c++) begin : g_trim
        iqmix_trim #(
            .DW(DATA_W), .GW(GAIN_W), .GF(GAIN_FRAC), .OW(OFS_W)
        ) u_trim (
            .clk   (clk),
            .rst_n (rst_n),
            .x     (mix_a[c]),
            .gain  (gain_a[c]),
            .ofs   (ofs_a[c]),
            .ob    (mode[MODE_OB_BIT]),
            .y     (y_a[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vp  = {st_q.vp[PIPE_DEPTH-2:0], in_vld};
        st_d.age = (st_q.age == 2'd3) ? st_q.age : st_q.age + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vp[PIPE_DEPTH-1];
    assign out_i   = y_a[0];
    assign out_q   = y_a[1];

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age == 2'd3) |-> (out_vld == $past(in_vld, 3))); // R10
endmodule

// File: tb/iq_upmixer_tb_top.sv
module iq_upmixer_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_vld = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic [3:0]         mode = 4'd0;
    logic [15:0]        gain_i = 16'd16384, gain_q = 16'd16384;
    logic signed [15:0] ofs_i = '0, ofs_q = '0;
    logic               out_vld;
    logic [15:0]        out_i, out_q;

    int n_chk = 0;
    int n_bad = 0;
    int n_b   = 0;

    always #5 clk = ~clk;

    iq_upmixer dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
        .mode(mode), .gain_i(gain_i), .gain_q(gain_q), .ofs_i(ofs_i), .ofs_q(ofs_q),
        .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] trimf(input int x, input int g, input int o, input bit ob);
        longint p;
        logic [15:0] r;
        p = (longint'(x) * longint'(g)) >>> 14;
        p = p + longint'(o);
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        r = p[15:0];
        if (ob) r[15] = ~r[15];
        return r;
    endfunction

    task automatic model(input int xi, input int xq, input int n,
                         output logic [15:0] ei, output logic [15:0] eq);
        int mi, mq, c;
        mi = xi; mq = xq;
        if (mode[1:0] == 2'd1) begin
            if (n % 2 == 1) begin mi = -xi; mq = -xq; end
        end else if (mode[1:0] == 2'd2) begin
            if (mode[2]) begin
                c = (n % 4 == 0) ? 1 : (n % 4 == 2) ? -1 : 0;
                mi = c * xi; mq = c * xq;
            end else begin
                case (n % 4)
                    0: begin mi = xi;  mq = xq;  end
                    1: begin mi = -xq; mq = xi;  end
                    2: begin mi = -xi; mq = -xq; end
                    default: begin mi = xq; mq = -xi; end
                endcase
            end
        end
        ei = trimf(mi, int'(gain_i), int'(ofs_i), mode[3]);
        eq = trimf(mq, int'(gain_q), int'(ofs_q), mode[3]);
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        if (m[2:0] != mode[2:0]) n_b = 0;
        mode = m;
        @(negedge clk);
    endtask

    task automatic set_trim(input int gi, input int gq, input int oi, input int oq);
        @(negedge clk);
        gain_i = 16'(gi); gain_q = 16'(gq);
        ofs_i = 16'(oi); ofs_q = 16'(oq);
    endtask

    // one isolated sample; checks latency and both channels
    task automatic send(input int xi, input int xq, input string req);
        logic [15:0] ei, eq;
        model(xi, xq, n_b, ei, eq);
        @(negedge clk);
        in_vld = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
        @(negedge clk);
        in_vld = 1'b0;
        chk(out_vld == 1'b0, "R10 early", int'(out_vld), 0);
        @(negedge clk);
        chk(out_vld == 1'b0, "R10 early", int'(out_vld), 0);
        @(negedge clk);
        chk(out_vld == 1'b1, "R10 valid", int'(out_vld), 1);
        chk(out_i == ei, {req, " I"}, int'(out_i), int'(ei));
        chk(out_q == eq, {req, " Q"}, int'(out_q), int'(eq));
        n_b++;
    endtask

    task automatic t_reset();
        chk(out_vld == 1'b0 && out_i == 16'd0 && out_q == 16'd0, "R1 in reset", int'(out_i), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(out_vld == 1'b0, "R1 after release", int'(out_vld), 0);
        chk(out_i == 16'd0 && out_q == 16'd0, "R1 outputs zero", int'(out_q), 0);
    endtask

    task automatic t_bypass();
        set_mode(4'b0000);
        set_trim(16384, 16384, 0, 0);
        send(1234, -4321, "R2 off");
        send(32767, -32768, "R2 off extremes");
        set_mode(4'b0011);
        send(-7, 99, "R2 rate code 3");
    endtask

    task automatic t_half();
        set_mode(4'b0001);
        send(500, -600, "R3 half n0");
        send(-32768, 32767, "R3 R8 half n1 clamp");
        send(700, 800, "R3 half n2");
        set_mode(4'b0101);
        send(300, -300, "R3 half real n0");
        send(300, -300, "R3 half real n1");
    endtask

    task automatic t_quarter_cplx();
        set_mode(4'b0010);
        for (int k = 0; k < 5; k++) send(1000 + k, 2000 - k, "R4 quarter complex");
    endtask

    task automatic t_quarter_real();
        set_mode(4'b0110);
        for (int k = 0; k < 4; k++) send(-1500, 2500, "R5 quarter real");
    endtask

    task automatic t_restart();
        set_mode(4'b0010);
        send(111, 222, "R6 pre n0");
        send(111, 222, "R6 pre n1");
        // idle cycles with in_vld low must not move the phase
        repeat (3) @(negedge clk);
        send(111, 222, "R6 idle no advance n2");
        set_mode(4'b0110);
        send(333, 444, "R6 restart real");
        set_mode(4'b0010);
        send(333, 444, "R6 restart complex");
        send(333, 444, "R6 after restart n1");
    endtask

    task automatic t_trim();
        set_mode(4'b0000);
        set_trim(32768, 8192, 25, -40);
        send(1000, 1000, "R7 gain 2 and 0.5");
        send(-3, -3, "R7 floor rounding");
        set_trim(16384, 16384, -100, 77);
        send(0, 0, "R7 offsets only");
    endtask

    task automatic t_clamp();
        set_mode(4'b0000);
        set_trim(65535, 65535, 0, 0);
        send(20000, -20000, "R8 gain overflow");
        set_trim(16384, 16384, 2000, -2000);
        send(32000, -32000, "R8 offset overflow");
    endtask

    task automatic t_offbin();
        set_trim(16384, 16384, 0, 0);
        set_mode(4'b1000);
        send(0, -1, "R9 offset binary mid");
        send(32767, -32768, "R9 offset binary ends");
        set_mode(4'b0000);
        send(-1, 5, "R9 twos complement");
    endtask

    task automatic t_stream();
        logic [15:0] ei [8];
        logic [15:0] eq [8];
        int base;
        set_trim(16384, 16384, 0, 0);
        set_mode(4'b0010);
        base = n_b;
        for (int k = 0; k < 8; k++) model(10 * k + 1, -20 * k - 3, base + k, ei[k], eq[k]);
        for (int k = 0; k < 11; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                chk(out_vld == 1'b1, "R10 stream valid", int'(out_vld), 1);
                chk(out_i == ei[k-3], "R10 R4 stream I", int'(out_i), int'(ei[k-3]));
                chk(out_q == eq[k-3], "R10 R4 stream Q", int'(out_q), int'(eq[k-3]));
            end
            if (k < 8) begin
                in_vld = 1'b1; in_i = 16'(10 * k + 1); in_q = 16'(-20 * k - 3);
            end else begin
                in_vld = 1'b0;
            end
        end
        @(negedge clk);
        chk(out_vld == 1'b0, "R10 stream end", int'(out_vld), 0);
        n_b = base + 8;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_bypass();
        t_half();
        t_quarter_cplx();
        t_quarter_real();
        t_restart();
        t_trim();
        t_clamp();
        t_offbin();
        t_stream();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule